// File: doc/BRIEF.md
# Vector Tail and Mask Policy Merge

This block forms the final destination register value of one vector operation. It takes the freshly computed result elements, the previous contents of the destination register, a per-element mask, a start index, a vector length and two policy bits. Each element position is put into one of four classes: before the start index, active body, inactive body, or tail. The class decides what is written: the new result, the old destination value, or an element of all ones.

The tail policy and the inactive-element policy are chosen independently. "Keep" (undisturbed) preserves the old value. "Fill" (agnostic) writes all ones, always and deterministically. Elements before the start index always keep their old value, and active body elements always take the new result. The element count, the element width and the presence of an output register are parameters. With the default settings the merged register appears one clock after its inputs.

Top module: `vec_policy_merge`

## Requirements
- R1: An element whose index i satisfies i < startIdx outputs its old value (oldElems lane i), whatever the mask, the policies or the new value.
- R2: A body element (startIdx <= i < vecLen) that is active outputs its new value (newElems lane i).
- R3: When useMask is 0, every body element is active, whatever its maskBits bit.
- R4: When useMask is 1, a body element whose maskBits bit is 0 is inactive. It outputs its old value when inactAgn is 0, and all ones when inactAgn is 1.
- R5: An element with i >= vecLen and i >= startIdx is a tail element. It outputs its old value when tailAgn is 0, and all ones when tailAgn is 1. A vecLen of NUM_ELEM or more leaves no tail elements.
- R6: tailAgn affects only tail elements and inactAgn affects only inactive body elements. Each of the four policy combinations gives its own result.
- R7: When startIdx > vecLen, elements in [vecLen, startIdx) count as before-start and keep their old values, even when tailAgn is 1.
- R8: With REG_OUT = 1 (the default), destElems shows the merge of the inputs present at a rising clock edge from just after that edge. While rstN is low, destElems is all zeros.
- R9: Element i occupies bits [i*ELEM_W +: ELEM_W] of newElems, oldElems and destElems. maskBits bit i belongs to element i, with bit 0 for element 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| newElems | input | NUM_ELEM*ELEM_W | Computed result elements |
| oldElems | input | NUM_ELEM*ELEM_W | Previous destination elements |
| maskBits | input | NUM_ELEM | Per-element mask, one bit per element |
| useMask | input | 1 | 1 = the operation is masked |
| startIdx | input | CNT_W | First body element index |
| vecLen | input | CNT_W | Vector length (end of body, exclusive) |
| tailAgn | input | 1 | Tail policy: 0 keep, 1 fill with ones |
| inactAgn | input | 1 | Inactive-element policy: 0 keep, 1 fill with ones |
| destElems | output | NUM_ELEM*ELEM_W | Merged destination elements |

## Verification
The hardest case to reach is a start index beyond the vector length, where before-start and tail ranges overlap. Random lengths and starts rarely produce it together with the fill-with-ones tail policy and a vecLen that is zero or at least NUM_ELEM. Directed steps place startIdx above vecLen with tailAgn set, use vecLen = 0 and vecLen beyond NUM_ELEM, and set the two policies to opposite values. A random phase then mixes all fields. Each cycle's output is compared, lane by lane, with a behavioural model that holds one pending expectation in a queue.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  // Classification of one element position
  typedef enum logic [1:0] {
    LANE_PRE   = 2'd0,
    LANE_ACT   = 2'd1,
    LANE_INACT = 2'd2,
    LANE_TAIL  = 2'd3
  } laneClass_e;

  // Strobes from control to datapath, one per lane
  typedef struct packed {
    logic takeNew;
    logic fillOnes;
  } laneStrobe_t;

endpackage

// File: rtl/vpm_ctrl.sv
module vpm_ctrl
  import vpm_pkg::*;
#(
  parameter int NUM_ELEM = 8,
  parameter int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic [CNT_W-1:0]          startIdx,
  input  logic [CNT_W-1:0]          vecLen,
  input  logic [NUM_ELEM-1:0]       maskBits,
  input  logic                      useMask,
  input  logic                      tailAgn,
  input  logic                      inactAgn,
  output laneStrobe_t [NUM_ELEM-1:0] laneStb
);

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
    localparam logic [CNT_W-1:0] LANE_IDX = CNT_W'(i);

    laneClass_e  laneCls;
    laneStrobe_t laneSel;
    logic        belowStart;
    logic        pastLen;
    logic        maskOn;

    always_comb begin
      belowStart = (LANE_IDX < startIdx);
      pastLen    = (LANE_IDX >= vecLen);
      maskOn     = !useMask || maskBits[i];
      // before-start wins over tail when the ranges overlap
      if (belowStart)   laneCls = LANE_PRE;
      else if (pastLen) laneCls = LANE_TAIL;
      else if (maskOn)  laneCls = LANE_ACT;
      else              laneCls = LANE_INACT;
    end

    always_comb begin
      laneSel = '0;
      unique case (laneCls)
        LANE_ACT:   laneSel.takeNew  = 1'b1;
        LANE_INACT: laneSel.fillOnes = inactAgn;
        LANE_TAIL:  laneSel.fillOnes = tailAgn;
        default:    laneSel          = '0;
      endcase
    end

    assign laneStb[i] = laneSel;
  end

endmodule

// File: rtl/vpm_dpath.sv
module vpm_dpath
  import vpm_pkg::*;
#(
  parameter int  NUM_ELEM = 8,
  parameter int  ELEM_W   = 16,
  parameter bit  REG_OUT  = 1'b1,
  localparam int TOT_W    = NUM_ELEM * ELEM_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  laneStrobe_t [NUM_ELEM-1:0] laneStb,
  input  logic [TOT_W-1:0]           newElems,
  input  logic [TOT_W-1:0]           oldElems,
  output logic [TOT_W-1:0]           destElems
);

  logic [TOT_W-1:0] mergedVec;

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_mux
    always_comb begin
      if (laneStb[i].takeNew)
        mergedVec[i*ELEM_W +: ELEM_W] = newElems[i*ELEM_W +: ELEM_W];
      else if (laneStb[i].fillOnes)
        mergedVec[i*ELEM_W +: ELEM_W] = {ELEM_W{1'b1}};
      else
        mergedVec[i*ELEM_W +: ELEM_W] = oldElems[i*ELEM_W +: ELEM_W];
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) destElems <= '0;
      else       destElems <= mergedVec;
    end
  end else begin : g_comb
    assign destElems = mergedVec;
  end

endmodule

// File: rtl/vec_policy_merge.sv
module vec_policy_merge
  import vpm_pkg::*;
#(
  parameter int  NUM_ELEM = 8,
  parameter int  ELEM_W   = 16,
  parameter bit  REG_OUT  = 1'b1,
  localparam int CNT_W    = $clog2(NUM_ELEM + 1),
  localparam int TOT_W    = NUM_ELEM * ELEM_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [TOT_W-1:0]    newElems,
  input  logic [TOT_W-1:0]    oldElems,
  input  logic [NUM_ELEM-1:0] maskBits,
  input  logic                useMask,
  input  logic [CNT_W-1:0]    startIdx,
  input  logic [CNT_W-1:0]    vecLen,
  input  logic                tailAgn,
  input  logic                inactAgn,
  output logic [TOT_W-1:0]    destElems
);

  laneStrobe_t [NUM_ELEM-1:0] laneStb;

  vpm_ctrl #(
    .NUM_ELEM (NUM_ELEM),
    .CNT_W    (CNT_W)
  ) ctrl_i (
    .startIdx (startIdx),
    .vecLen   (vecLen),
    .maskBits (maskBits),
    .useMask  (useMask),
    .tailAgn  (tailAgn),
    .inactAgn (inactAgn),
    .laneStb  (laneStb)
  );

  vpm_dpath #(
    .NUM_ELEM (NUM_ELEM),
    .ELEM_W   (ELEM_W),
    .REG_OUT  (REG_OUT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .laneStb   (laneStb),
    .newElems  (newElems),
    .oldElems  (oldElems),
    .destElems (destElems)
  );

endmodule

// File: rtl/vpm_chk.sv
module vpm_chk #(
  parameter int  NUM_ELEM = 8,
  parameter int  ELEM_W   = 16,
  parameter bit  REG_OUT  = 1'b1,
  localparam int CNT_W    = $clog2(NUM_ELEM + 1),
  localparam int TOT_W    = NUM_ELEM * ELEM_W
) (
  input logic                clk,
  input logic                rstN,
  input logic [TOT_W-1:0]    newElems,
  input logic [TOT_W-1:0]    oldElems,
  input logic [NUM_ELEM-1:0] maskBits,
  input logic                useMask,
  input logic [CNT_W-1:0]    startIdx,
  input logic [CNT_W-1:0]    vecLen,
  input logic                tailAgn,
  input logic                inactAgn,
  input logic [TOT_W-1:0]    destElems
);

  logic [TOT_W-1:0]    shNew, shOld;
  logic [NUM_ELEM-1:0] shMask;
  logic                shUseMask, shTail, shInact, chkValid;
  logic [CNT_W-1:0]    shStart, shLen;

  if (REG_OUT) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chkValid <= 1'b0;
        shNew <= '0; shOld <= '0; shMask <= '0; shUseMask <= 1'b0;
        shTail <= 1'b0; shInact <= 1'b0; shStart <= '0; shLen <= '0;
      end else begin
        chkValid <= 1'b1;
        shNew <= newElems; shOld <= oldElems; shMask <= maskBits;
        shUseMask <= useMask; shTail <= tailAgn; shInact <= inactAgn;
        shStart <= startIdx; shLen <= vecLen;
      end
    end
  end else begin : g_direct
    assign chkValid = 1'b1;
    assign shNew = newElems;   assign shOld = oldElems;
    assign shMask = maskBits;  assign shUseMask = useMask;
    assign shTail = tailAgn;   assign shInact = inactAgn;
    assign shStart = startIdx; assign shLen = vecLen;
  end

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
    localparam logic [CNT_W-1:0] LI = CNT_W'(i);
    logic [ELEM_W-1:0] outLane, newLane, oldLane;
    assign outLane = destElems[i*ELEM_W +: ELEM_W];
    assign newLane = shNew[i*ELEM_W +: ELEM_W];
    assign oldLane = shOld[i*ELEM_W +: ELEM_W];

    // R1 R7
    prestart_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chkValid && LI < shStart) |-> outLane == oldLane);

    // R2 R3
    active_new_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chkValid && LI >= shStart && LI < shLen && (!shUseMask || shMask[i]))
        |-> outLane == newLane);

    // R4
    inactive_policy_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chkValid && LI >= shStart && LI < shLen && shUseMask && !shMask[i])
        |-> outLane == (shInact ? {ELEM_W{1'b1}} : oldLane));

    // R5
    tail_policy_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chkValid && LI >= shStart && LI >= shLen)
        |-> outLane == (shTail ? {ELEM_W{1'b1}} : oldLane));
  end

endmodule

bind vec_policy_merge vpm_chk #(
  .NUM_ELEM (NUM_ELEM),
  .ELEM_W   (ELEM_W),
  .REG_OUT  (REG_OUT)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .newElems  (newElems),
  .oldElems  (oldElems),
  .maskBits  (maskBits),
  .useMask   (useMask),
  .startIdx  (startIdx),
  .vecLen    (vecLen),
  .tailAgn   (tailAgn),
  .inactAgn  (inactAgn),
  .destElems (destElems)
);

// File: tb/vec_policy_merge_tb_top.sv
module vec_policy_merge_tb_top;

  localparam int NUM_ELEM = 8;
  localparam int ELEM_W   = 16;
  localparam int CNT_W    = $clog2(NUM_ELEM + 1);
  localparam int TOT_W    = NUM_ELEM * ELEM_W;

  typedef struct {
    logic [TOT_W-1:0] expVec;
    int               start;
    int               len;
    bit               um;
    bit               ta;
    bit               ia;
  } pend_t;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [TOT_W-1:0]    newElems = '0, oldElems = '0;
  logic [NUM_ELEM-1:0] maskBits = '0;
  logic                useMask = 1'b0, tailAgn = 1'b0, inactAgn = 1'b0;
  logic [CNT_W-1:0]    startIdx = '0, vecLen = '0;
  logic [TOT_W-1:0]    destElems;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  pend_t pendQ[$];

  always #4 clk = ~clk;  // 125 MHz

  vec_policy_merge #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .newElems(newElems), .oldElems(oldElems),
    .maskBits(maskBits), .useMask(useMask), .startIdx(startIdx), .vecLen(vecLen),
    .tailAgn(tailAgn), .inactAgn(inactAgn), .destElems(destElems)
  );

  function automatic logic [TOT_W-1:0] modelMerge(
      logic [TOT_W-1:0] nv, logic [TOT_W-1:0] ov, logic [NUM_ELEM-1:0] m,
      bit um, int st, int ln, bit ta, bit ia);
    logic [TOT_W-1:0] r;
    for (int i = 0; i < NUM_ELEM; i++) begin
      logic [ELEM_W-1:0] o = ov[i*ELEM_W +: ELEM_W];
      if (i < st)             r[i*ELEM_W +: ELEM_W] = o;
      else if (i >= ln)       r[i*ELEM_W +: ELEM_W] = ta ? '1 : o;
      else if (!um || m[i])   r[i*ELEM_W +: ELEM_W] = nv[i*ELEM_W +: ELEM_W];
      else                    r[i*ELEM_W +: ELEM_W] = ia ? '1 : o;
    end
    return r;
  endfunction

  function automatic string laneTag(pend_t p, int i, logic [NUM_ELEM-1:0] m);
    string t;
    if (i < p.start)     t = (i >= p.len) ? "R7" : "R1";
    else if (i >= p.len) t = "R5";
    else if (!p.um)      t = "R3";
    else if (m[i])       t = "R2";
    else                 t = "R4";
    if (p.ta != p.ia) t = {t, "/R6"};
    return {t, " R9"};
  endfunction

  pend_t lastDrive;
  logic [NUM_ELEM-1:0] lastMask;

  task automatic compareFront();
    pend_t p;
    if (pendQ.size() == 0) return;
    p = pendQ.pop_front();
    for (int i = 0; i < NUM_ELEM; i++) begin
      total++;
      if (destElems[i*ELEM_W +: ELEM_W] !== p.expVec[i*ELEM_W +: ELEM_W]) begin
        bad++;
        $display("FAIL %s lane %0d: got %h expected %h", laneTag(p, i, lastMask), i,
                 destElems[i*ELEM_W +: ELEM_W], p.expVec[i*ELEM_W +: ELEM_W]);
      end
    end
  endtask

  // one step: check previous expectation, then drive new inputs
  task automatic step(logic [TOT_W-1:0] nv, logic [TOT_W-1:0] ov, logic [NUM_ELEM-1:0] m,
                      bit um, int st, int ln, bit ta, bit ia);
    pend_t p;
    @(negedge clk);
    compareFront();
    newElems = nv; oldElems = ov; maskBits = m; useMask = um;
    startIdx = CNT_W'(st); vecLen = CNT_W'(ln); tailAgn = ta; inactAgn = ia;
    p.expVec = modelMerge(nv, ov, m, um, st, ln, ta, ia);
    p.start = st; p.len = ln; p.um = um; p.ta = ta; p.ia = ia;
    lastMask = m;
    pendQ.push_back(p);
  endtask

  function automatic logic [TOT_W-1:0] rndVec();
    logic [TOT_W-1:0] v;
    for (int i = 0; i < TOT_W / 32 + 1; i++) v = {v[TOT_W-33:0], 32'($urandom)};
    return v;
  endfunction

  initial begin
    logic [TOT_W-1:0] nA, oA;
    nA = rndVec();
    oA = rndVec();
    newElems = nA; oldElems = oA; tailAgn = 1'b1; vecLen = CNT_W'(3);
    repeat (2) @(negedge clk);
    // R8: zero while reset is held
    total++;
    if (destElems !== '0) begin
      bad++;
      $display("FAIL R8 reset value: got %h expected %h", destElems, {TOT_W{1'b0}});
    end
    rstN = 1'b1;

    // R2 R3: unmasked full body, mask bits ignored
    step(nA, oA, 8'h5A, 1'b0, 0, 8, 1'b1, 1'b1);
    // R4 R5 R6: masked partial body, opposite policies both ways
    step(nA, oA, 8'b1010_0110, 1'b1, 2, 6, 1'b1, 1'b0);
    step(nA, oA, 8'b1010_0110, 1'b1, 2, 6, 1'b0, 1'b1);
    step(nA, oA, 8'b1010_0110, 1'b1, 2, 6, 1'b0, 1'b0);
    step(nA, oA, 8'b1010_0110, 1'b1, 2, 6, 1'b1, 1'b1);
    // R7: start beyond length with fill tail policy
    step(nA, oA, 8'hFF, 1'b0, 5, 3, 1'b1, 1'b1);
    // R5: zero length, all tail
    step(nA, oA, 8'h00, 1'b1, 0, 0, 1'b1, 1'b0);
    // R5: length beyond element count, no tail
    step(nA, oA, 8'h0F, 1'b1, 0, 15, 1'b1, 1'b0);
    // R1: start at element count, everything keeps old
    step(nA, oA, 8'hFF, 1'b0, 8, 8, 1'b1, 1'b1);
    // R9: single-lane mask walks across lanes
    for (int k = 0; k < NUM_ELEM; k++)
      step(rndVec(), rndVec(), NUM_ELEM'(1) << k, 1'b1, 0, 8, 1'b1, 1'b1);

    for (int k = 0; k < 300; k++)
      step(rndVec(), rndVec(), NUM_ELEM'($urandom), 1'($urandom),
           int'($urandom_range(0, 9)), int'($urandom_range(0, 15)),
           1'($urandom), 1'($urandom));
    @(negedge clk);
    compareFront();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule